// File: doc/BRIEF.md
# Redundancy-Aware Neighbor Sampler

This block walks a batch of target vertices through a temporal neighbour table and emits every interaction edge to the message stage only once. Targets are loaded one per cycle while the block is idle, and each is tagged with its most recent timestamp. They are kept sorted as they arrive, newest first. A `go` pulse starts the walk. The block then takes the targets as roots in that order. For each root it reads the neighbour count and then each stored (neighbour, timestamp) pair from the table.

A bitmap over vertex ids records every vertex that has already been touched in the batch. A root is marked when its expansion starts. A neighbour that is found unmarked is sent out as an edge and then marked. A marked neighbour is skipped without any output. A target that was already reached as someone's neighbour is therefore expanded normally, but only its still-unmarked neighbours produce edges. The edge stream uses valid/ready. A one-cycle `done` pulse ends the batch, and the target list is then empty for the next batch.

Top module: `nbr_sampler`

## Requirements
- R1: While idle, each cycle with `tgt_load` high adds one target (id, timestamp) to the batch. The first MAX_TGT (8) loads of a batch are kept and any further loads are dropped.
- R2: Roots are expanded in descending order of their loaded timestamp. On equal timestamps the lower vertex id goes first, and duplicates keep their load order.
- R3: After reset the block is idle with `s_valid`, `done`, `cnt_rd_en` and `tri_rd_en` low. A `go` sampled while idle clears the visited bitmap. With an empty list, `done` is high in the cycle after the second rising edge counted from the edge that samples `go`.
- R4: A root is marked visited when its expansion begins. Any neighbour entry naming an already marked vertex (the root itself, an earlier root, or an earlier sampled neighbour) produces no edge.
- R5: Each unmarked neighbour entry produces exactly one edge (root, neighbour, entry timestamp) and marks the neighbour. Within a root, edges follow the table entry index order 0, 1, 2, ...
- R6: For each root the block raises `cnt_rd_en` with `cnt_rd_root` equal to the root id. It uses the count returned on `cnt_rd_data` one cycle later and clamps values above MAX_DEG (32) to MAX_DEG.
- R7: A neighbour entry is read with `tri_rd_en` at address root x MAX_DEG + index: the root id sits in the upper bits and the index in the lower log2(MAX_DEG) bits. Its neighbour and timestamp are taken one cycle later.
- R8: While `s_valid` is high and `s_ready` is low, `s_valid` stays high and `s_root`, `s_nbr` and `s_ts` stay unchanged.
- R9: `done` is a single-cycle pulse. It follows the check of the last root's last entry, with the last edge already accepted and no `s_valid` after it. The target list is empty afterwards.
- R10: `go` and `tgt_load` have no effect while a batch is being walked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_load | input | 1 | Add one target to the batch (idle only) |
| tgt_id | input | 6 | Target vertex id |
| tgt_ts | input | 16 | Target's latest timestamp |
| go | input | 1 | Start walking the loaded batch |
| done | output | 1 | One-cycle end-of-batch pulse |
| cnt_rd_en | output | 1 | Neighbour count read strobe |
| cnt_rd_root | output | 6 | Root id for the count read |
| cnt_rd_data | input | 8 | Neighbour count, one cycle after the strobe |
| tri_rd_en | output | 1 | Neighbour entry read strobe |
| tri_rd_addr | output | 11 | Entry address {root, index} |
| tri_rd_nbr | input | 6 | Entry neighbour id, one cycle after the strobe |
| tri_rd_ts | input | 16 | Entry timestamp, one cycle after the strobe |
| s_valid | output | 1 | Sampled edge valid |
| s_ready | input | 1 | Downstream accepts the edge |
| s_root | output | 6 | Edge root vertex |
| s_nbr | output | 6 | Edge neighbour vertex |
| s_ts | output | 16 | Edge timestamp |

## Verification
Table reads answer one cycle after their strobe, so the bench's table model registers its reply on the same edge that sees the strobe. The count and entry data are therefore present in the very cycle the walker consumes them. An empty batch has a fixed latency: `done` is up after the second edge following the `go` edge and down after the third, and the bench samples those exact cycles. Edge results have no fixed latency, because skips and the ready pattern stretch them. The bench therefore drives `s_ready` at the falling edge and samples all outputs 2 ns later, recording handshakes until `done`, and then compares the recorded list in order against a model built from the requirements. At each of those mid-cycle samples, a stall from the previous cycle must show identical edge fields.

// File: rtl/nsamp_pkg.sv
package nsamp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SORT,
    ST_FETCH_CNT,
    ST_FETCH_TRIPLE,
    ST_CHECK,
    ST_EMIT,
    ST_NEXT
  } walk_state_e;

endpackage

// File: rtl/nsamp_target_sorter.sv
module nsamp_target_sorter #(
  parameter int MAX_TGT = 8,
  parameter int ID_W    = 6,
  parameter int TS_W    = 16,
  localparam int CNT_W  = $clog2(MAX_TGT + 1),
  localparam int PTR_W  = $clog2(MAX_TGT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [ID_W-1:0]  ins_id,
  input  logic [TS_W-1:0]  ins_ts,
  input  logic             clr,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [ID_W-1:0]  rd_id,
  output logic [CNT_W-1:0] n_tgt
);

  logic [ID_W-1:0]  id_q [MAX_TGT];
  logic [ID_W-1:0]  id_d [MAX_TGT];
  logic [TS_W-1:0]  ts_q [MAX_TGT];
  logic [TS_W-1:0]  ts_d [MAX_TGT];
  logic [CNT_W-1:0] n_q, n_d;
  logic [MAX_TGT:0] ahead;   // ahead[i+1]: new entry goes in front of slot i
  logic             full, accept;

  assign full   = (n_q == CNT_W'(MAX_TGT));
  assign accept = ins_en && !full;

  // insertion point: first slot that the new entry precedes
  always_comb begin
    ahead[0] = 1'b0;
    for (int i = 0; i < MAX_TGT; i++) begin
      ahead[i+1] = (CNT_W'(i) >= n_q) ||
                   (ins_ts > ts_q[i]) ||
                   ((ins_ts == ts_q[i]) && (ins_id < id_q[i]));
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_TGT; i++) begin
      id_d[i] = id_q[i];
      ts_d[i] = ts_q[i];
      if (accept) begin
        if (ahead[i+1] && !ahead[i]) begin
          id_d[i] = ins_id;
          ts_d[i] = ins_ts;
        end else if (ahead[i] && (i > 0)) begin
          id_d[i] = id_q[(i > 0) ? i - 1 : 0];
          ts_d[i] = ts_q[(i > 0) ? i - 1 : 0];
        end
      end
    end
    if (clr)         n_d = '0;
    else if (accept) n_d = n_q + CNT_W'(1);
    else             n_d = n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      for (int i = 0; i < MAX_TGT; i++) begin
        id_q[i] <= '0;
        ts_q[i] <= '0;
      end
    end else begin
      n_q <= n_d;
      if (accept) begin
        for (int i = 0; i < MAX_TGT; i++) begin
          id_q[i] <= id_d[i];
          ts_q[i] <= ts_d[i];
        end
      end
    end
  end

  assign rd_id = id_q[rd_idx];
  assign n_tgt = n_q;

  // list stays ordered newest first, lower id first on ties (R2)
  generate
    for (genvar g = 0; g < MAX_TGT - 1; g++) begin : g_order_chk
      p_sorted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(g + 1) < n_q) |->
          ((ts_q[g] > ts_q[g+1]) ||
           ((ts_q[g] == ts_q[g+1]) && (id_q[g] <= id_q[g+1]))));
    end
  endgenerate

  // a full list drops further loads (R1)
  p_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ins_en && !clr) |=> (n_q == CNT_W'(MAX_TGT)));

endmodule

// File: rtl/nsamp_visited.sv
module nsamp_visited #(
  parameter int N_VTX = 64,
  localparam int ID_W = $clog2(N_VTX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            set_en,
  input  logic [ID_W-1:0] set_id,
  input  logic [ID_W-1:0] q_id,
  output logic            q_hit
);

  logic [N_VTX-1:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (clr)         bits_d = '0;
    else if (set_en) bits_d[set_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign q_hit = bits_q[q_id];

  // a marked vertex reads back as visited (R4)
  p_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr) |=> bits_q[$past(set_id)]);

  // batch start wipes the set (R3)
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bits_q == '0));

endmodule

// File: rtl/nsamp_walker.sv
module nsamp_walker
  import nsamp_pkg::*;
#(
  parameter int MAX_TGT  = 8,
  parameter int MAX_DEG  = 32,
  parameter int ID_W     = 6,
  parameter int TS_W     = 16,
  parameter int CNT_IN_W = 8,
  localparam int CNT_W   = $clog2(MAX_TGT + 1),
  localparam int PTR_W   = $clog2(MAX_TGT),
  localparam int LIDX_W  = $clog2(MAX_DEG),
  localparam int IDX_W   = $clog2(MAX_DEG + 1),
  localparam int ADDR_W  = ID_W + LIDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [CNT_W-1:0]    n_tgt,
  input  logic [ID_W-1:0]     root_id,
  output logic [PTR_W-1:0]    tgt_idx,
  output logic                list_clr,
  output logic                busy,
  output logic                cnt_rd_en,
  output logic [ID_W-1:0]     cnt_rd_root,
  input  logic [CNT_IN_W-1:0] cnt_rd_data,
  output logic                tri_rd_en,
  output logic [ADDR_W-1:0]   tri_rd_addr,
  input  logic [ID_W-1:0]     tri_rd_nbr,
  input  logic [TS_W-1:0]     tri_rd_ts,
  output logic                vis_clr,
  output logic                vis_set,
  output logic [ID_W-1:0]     vis_set_id,
  input  logic                vis_hit,
  output logic                s_valid,
  input  logic                s_ready,
  output logic [ID_W-1:0]     s_root,
  output logic [ID_W-1:0]     s_nbr,
  output logic [TS_W-1:0]     s_ts,
  output logic                done
);

  walk_state_e      state_q, state_d;
  logic [PTR_W-1:0] tidx_q, tidx_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] deg_q, deg_d;
  logic             cnt_load_q, cnt_load_d;
  logic [ID_W-1:0]  e_root_q, e_root_d;
  logic [ID_W-1:0]  e_nbr_q, e_nbr_d;
  logic [TS_W-1:0]  e_ts_q, e_ts_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] cnt_clamp, eff_deg;
  logic             last_tgt;

  assign cnt_clamp = (cnt_rd_data > CNT_IN_W'(MAX_DEG)) ? IDX_W'(MAX_DEG)
                                                         : cnt_rd_data[IDX_W-1:0];
  // the count arrives in the first FETCH_TRIPLE cycle after its read
  assign eff_deg   = cnt_load_q ? cnt_clamp : deg_q;
  assign last_tgt  = ((CNT_W'(tidx_q) + CNT_W'(1)) == n_tgt);

  always_comb begin
    state_d    = state_q;
    tidx_d     = tidx_q;
    idx_d      = idx_q;
    deg_d      = deg_q;
    cnt_load_d = cnt_load_q;
    e_root_d   = e_root_q;
    e_nbr_d    = e_nbr_q;
    e_ts_d     = e_ts_q;
    done_d     = 1'b0;
    cnt_rd_en  = 1'b0;
    tri_rd_en  = 1'b0;
    vis_clr    = 1'b0;
    vis_set    = 1'b0;
    vis_set_id = root_id;
    list_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) state_d = ST_SORT;
      end
      ST_SORT: begin
        vis_clr = 1'b1;
        tidx_d  = '0;
        if (n_tgt == '0) begin
          done_d   = 1'b1;
          list_clr = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          state_d = ST_FETCH_CNT;
        end
      end
      ST_FETCH_CNT: begin
        cnt_rd_en  = 1'b1;
        vis_set    = 1'b1;
        idx_d      = '0;
        cnt_load_d = 1'b1;
        state_d    = ST_FETCH_TRIPLE;
      end
      ST_FETCH_TRIPLE: begin
        cnt_load_d = 1'b0;
        deg_d      = eff_deg;
        if (idx_q >= eff_deg) begin
          state_d = ST_NEXT;
        end else begin
          tri_rd_en = 1'b1;
          state_d   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!vis_hit) begin
          vis_set    = 1'b1;
          vis_set_id = tri_rd_nbr;
          e_root_d   = root_id;
          e_nbr_d    = tri_rd_nbr;
          e_ts_d     = tri_rd_ts;
          state_d    = ST_EMIT;
        end else begin
          idx_d   = idx_q + IDX_W'(1);
          state_d = ST_FETCH_TRIPLE;
        end
      end
      ST_EMIT: begin
        if (s_ready) begin
          idx_d   = idx_q + IDX_W'(1);
          state_d = ST_FETCH_TRIPLE;
        end
      end
      ST_NEXT: begin
        if (last_tgt) begin
          done_d   = 1'b1;
          list_clr = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          tidx_d  = tidx_q + PTR_W'(1);
          state_d = ST_FETCH_CNT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tidx_q     <= '0;
      idx_q      <= '0;
      deg_q      <= '0;
      cnt_load_q <= 1'b0;
      e_root_q   <= '0;
      e_nbr_q    <= '0;
      e_ts_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      tidx_q     <= tidx_d;
      idx_q      <= idx_d;
      deg_q      <= deg_d;
      cnt_load_q <= cnt_load_d;
      done_q     <= done_d;
      if (state_q == ST_CHECK) begin
        e_root_q <= e_root_d;
        e_nbr_q  <= e_nbr_d;
        e_ts_q   <= e_ts_d;
      end
    end
  end

  // address generation: root in the high bits, entry index in the low bits
  assign cnt_rd_root = root_id;
  assign tri_rd_addr = {root_id, idx_q[LIDX_W-1:0]};
  assign tgt_idx     = tidx_q;
  assign busy        = (state_q != ST_IDLE);
  assign s_valid     = (state_q == ST_EMIT);
  assign s_root      = e_root_q;
  assign s_nbr       = e_nbr_q;
  assign s_ts        = e_ts_q;
  assign done        = done_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=>
      (s_valid && $stable(s_root) && $stable(s_nbr) && $stable(s_ts)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!s_valid && !busy));

  p_rd_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_rd_en && tri_rd_en));

  // a count read is always followed by the entry stage (R6)
  p_cnt_then_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd_en |=> (state_q == ST_FETCH_TRIPLE));

endmodule

// File: rtl/nbr_sampler.sv
module nbr_sampler #(
  parameter int N_VTX    = 64,
  parameter int MAX_TGT  = 8,
  parameter int MAX_DEG  = 32,
  parameter int TS_W     = 16,
  parameter int CNT_IN_W = 8,
  localparam int ID_W    = $clog2(N_VTX),
  localparam int ADDR_W  = ID_W + $clog2(MAX_DEG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tgt_load,
  input  logic [ID_W-1:0]     tgt_id,
  input  logic [TS_W-1:0]     tgt_ts,
  input  logic                go,
  output logic                done,
  output logic                cnt_rd_en,
  output logic [ID_W-1:0]     cnt_rd_root,
  input  logic [CNT_IN_W-1:0] cnt_rd_data,
  output logic                tri_rd_en,
  output logic [ADDR_W-1:0]   tri_rd_addr,
  input  logic [ID_W-1:0]     tri_rd_nbr,
  input  logic [TS_W-1:0]     tri_rd_ts,
  output logic                s_valid,
  input  logic                s_ready,
  output logic [ID_W-1:0]     s_root,
  output logic [ID_W-1:0]     s_nbr,
  output logic [TS_W-1:0]     s_ts
);

  localparam int CNT_W = $clog2(MAX_TGT + 1);
  localparam int PTR_W = $clog2(MAX_TGT);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             busy, list_clr;
  logic [CNT_W-1:0] n_tgt;
  logic [PTR_W-1:0] tgt_idx;
  logic [ID_W-1:0]  root_id;
  logic             vis_clr, vis_set, vis_hit;
  logic [ID_W-1:0]  vis_set_id;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  nsamp_target_sorter #(
    .MAX_TGT (MAX_TGT),
    .ID_W    (ID_W),
    .TS_W    (TS_W)
  ) u_sorter (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ins_en (tgt_load && !busy),
    .ins_id (tgt_id),
    .ins_ts (tgt_ts),
    .clr    (list_clr),
    .rd_idx (tgt_idx),
    .rd_id  (root_id),
    .n_tgt  (n_tgt)
  );

  nsamp_visited #(
    .N_VTX (N_VTX)
  ) u_visited (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (vis_clr),
    .set_en (vis_set),
    .set_id (vis_set_id),
    .q_id   (tri_rd_nbr),
    .q_hit  (vis_hit)
  );

  nsamp_walker #(
    .MAX_TGT  (MAX_TGT),
    .MAX_DEG  (MAX_DEG),
    .ID_W     (ID_W),
    .TS_W     (TS_W),
    .CNT_IN_W (CNT_IN_W)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .go          (go),
    .n_tgt       (n_tgt),
    .root_id     (root_id),
    .tgt_idx     (tgt_idx),
    .list_clr    (list_clr),
    .busy        (busy),
    .cnt_rd_en   (cnt_rd_en),
    .cnt_rd_root (cnt_rd_root),
    .cnt_rd_data (cnt_rd_data),
    .tri_rd_en   (tri_rd_en),
    .tri_rd_addr (tri_rd_addr),
    .tri_rd_nbr  (tri_rd_nbr),
    .tri_rd_ts   (tri_rd_ts),
    .vis_clr     (vis_clr),
    .vis_set     (vis_set),
    .vis_set_id  (vis_set_id),
    .vis_hit     (vis_hit),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .s_root      (s_root),
    .s_nbr       (s_nbr),
    .s_ts        (s_ts),
    .done        (done)
  );

endmodule

// File: tb/test_nbr_sampler.sv
`timescale 1ns/1ps
module test_nbr_sampler;

  localparam int NV = 64;
  localparam int MD = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tgt_load;
  logic [5:0]  tgt_id;
  logic [15:0] tgt_ts;
  logic        go;
  logic        done;
  logic        cnt_rd_en;
  logic [5:0]  cnt_rd_root;
  logic [7:0]  cnt_rd_data;
  logic        tri_rd_en;
  logic [10:0] tri_rd_addr;
  logic [5:0]  tri_rd_nbr;
  logic [15:0] tri_rd_ts;
  logic        s_valid;
  logic        s_ready;
  logic [5:0]  s_root;
  logic [5:0]  s_nbr;
  logic [15:0] s_ts;

  always #5 clk = ~clk;

  nbr_sampler i_nbr_sampler (
    .clk(clk), .rst_n(rst_n), .tgt_load(tgt_load), .tgt_id(tgt_id),
    .tgt_ts(tgt_ts), .go(go), .done(done), .cnt_rd_en(cnt_rd_en),
    .cnt_rd_root(cnt_rd_root), .cnt_rd_data(cnt_rd_data),
    .tri_rd_en(tri_rd_en), .tri_rd_addr(tri_rd_addr),
    .tri_rd_nbr(tri_rd_nbr), .tri_rd_ts(tri_rd_ts), .s_valid(s_valid),
    .s_ready(s_ready), .s_root(s_root), .s_nbr(s_nbr), .s_ts(s_ts)
  );

  // neighbour table model, one-cycle read latency (R6, R7)
  logic [7:0]  cnt_mem [NV];
  logic [5:0]  nbr_mem [NV*MD];
  logic [15:0] ts_mem  [NV*MD];

  always @(posedge clk) begin
    if (cnt_rd_en) cnt_rd_data <= cnt_mem[cnt_rd_root];
    if (tri_rd_en) begin
      tri_rd_nbr <= nbr_mem[tri_rd_addr];
      tri_rd_ts  <= ts_mem[tri_rd_addr];
    end
  end

  // stimulus vectors: {batch[3:0], id[5:0], ts[15:0]}
  localparam int NVEC = 19;
  localparam logic [25:0] VEC [NVEC] = '{
    {4'd0, 6'd3,  16'd50},  {4'd0, 6'd17, 16'd90},
    {4'd0, 6'd40, 16'd90},  {4'd0, 6'd5,  16'd10},
    {4'd1, 6'd20, 16'd5},   {4'd1, 6'd8,  16'd100},
    {4'd1, 6'd12, 16'd250}, {4'd1, 6'd1,  16'd200},
    {4'd1, 6'd9,  16'd300},
    {4'd2, 6'd30, 16'd7},   {4'd2, 6'd31, 16'd9},
    {4'd2, 6'd32, 16'd7},   {4'd2, 6'd33, 16'd2},
    {4'd2, 6'd34, 16'd11},  {4'd2, 6'd35, 16'd9},
    {4'd2, 6'd36, 16'd1},   {4'd2, 6'd37, 16'd40},
    {4'd2, 6'd38, 16'd60},  {4'd2, 6'd39, 16'd80}
  };

  int n_checks = 0;
  int n_fail   = 0;

  int kid [8];
  int kts [8];
  int nk;
  int exp_root [512];
  int exp_nbr  [512];
  int exp_ts   [512];
  int n_exp;
  int got_root [512];
  int got_nbr  [512];
  int got_ts   [512];
  int n_got;
  bit got_done;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // R1 record of kept loads
  task automatic load_tgt(input int id, input int ts);
    @(negedge clk);
    tgt_load = 1'b1;
    tgt_id   = 6'(id);
    tgt_ts   = 16'(ts);
    if (nk < 8) begin
      kid[nk] = id;
      kts[nk] = ts;
      nk++;
    end
    @(negedge clk);
    tgt_load = 1'b0;
  endtask

  function automatic bit precedes(input int ta, input int ia, input int tb, input int ib);
    return (ta > tb) || ((ta == tb) && (ia < ib));
  endfunction

  // expected edges from R2, R4, R5, R6
  task automatic build_expected();
    int oid [8];
    int ots [8];
    bit vis [NV];
    for (int i = 0; i < nk; i++) begin
      int j = i;
      while ((j > 0) && precedes(kts[i], kid[i], ots[j-1], oid[j-1])) begin
        oid[j] = oid[j-1];
        ots[j] = ots[j-1];
        j--;
      end
      oid[j] = kid[i];
      ots[j] = kts[i];
    end
    for (int v = 0; v < NV; v++) vis[v] = 1'b0;
    n_exp = 0;
    for (int r = 0; r < nk; r++) begin
      int root = oid[r];
      int deg  = (cnt_mem[root] > MD) ? MD : int'(cnt_mem[root]);
      vis[root] = 1'b1;
      for (int i = 0; i < deg; i++) begin
        int nb = int'(nbr_mem[root*MD + i]);
        if (!vis[nb]) begin
          exp_root[n_exp] = root;
          exp_nbr[n_exp]  = nb;
          exp_ts[n_exp]   = int'(ts_mem[root*MD + i]);
          n_exp++;
          vis[nb] = 1'b1;
        end
      end
    end
  endtask

  // run a loaded batch; poke drives go and a load mid-walk (R10)
  task automatic run_batch(input int mode, input bit poke);
    bit prev_stall = 1'b0;
    int pr, pn, pt;
    n_got = 0;
    got_done = 1'b0;
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int cyc = 0; cyc < 4000 && !got_done; cyc++) begin
      @(negedge clk);
      tgt_load = poke && (cyc == 5);
      go       = poke && (cyc == 5);
      tgt_id   = 6'd50;
      tgt_ts   = 16'd999;
      case (mode)
        0:       s_ready = 1'b1;
        1:       s_ready = (cyc % 3) != 0;
        default: s_ready = (cyc % 4) >= 2;
      endcase
      #2;
      if (prev_stall) begin
        chk(s_valid && (int'(s_root) == pr) && (int'(s_nbr) == pn) && (int'(s_ts) == pt),
            "R8 held edge", {s_valid, s_root, s_nbr}, {1'b1, 6'(pr), 6'(pn)});
      end
      prev_stall = s_valid && !s_ready;
      pr = int'(s_root); pn = int'(s_nbr); pt = int'(s_ts);
      if (s_valid && s_ready && n_got < 512) begin
        got_root[n_got] = int'(s_root);
        got_nbr[n_got]  = int'(s_nbr);
        got_ts[n_got]   = int'(s_ts);
        n_got++;
      end
      if (done) begin
        got_done = 1'b1;
        chk(!s_valid, "R9 no valid with done", s_valid, 0);
      end
    end
    tgt_load = 1'b0;
    go = 1'b0;
    chk(got_done, "R9 done reached", got_done, 1);
    @(negedge clk);
    #2;
    chk(!done, "R9 done single pulse", done, 0);
  endtask

  task automatic compare_edges(input int b);
    chk(n_got == n_exp, $sformatf("R5 edge count batch %0d", b), n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      // R2 order, R4 skip, R5 content, R6 clamp, R7 address
      chk((got_root[i] == exp_root[i]) && (got_nbr[i] == exp_nbr[i]) && (got_ts[i] == exp_ts[i]),
          $sformatf("R2/R4/R5/R6/R7 edge %0d batch %0d root/nbr/ts", i, b),
          got_root[i]*1000000 + got_nbr[i]*100000 + got_ts[i],
          exp_root[i]*1000000 + exp_nbr[i]*100000 + exp_ts[i]);
    end
  endtask

  // empty batch: done exactly after the second edge past go (R3, R9)
  task automatic empty_batch(input string tag);
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    #2;
    chk(!done, {tag, " R3 done not early"}, done, 0);
    @(negedge clk);
    #2;
    chk(done, {tag, " R3 done on time"}, done, 1);
    @(negedge clk);
    #2;
    chk(!done, {tag, " R9 done drops"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      cnt_mem[v] = 8'((v*5 + 3) % 7);
      for (int i = 0; i < MD; i++) begin
        nbr_mem[v*MD + i] = 6'((v*7 + i*13 + 1) % NV);
        ts_mem[v*MD + i]  = 16'(v*100 + i);
      end
    end
    cnt_mem[9]  = 8'd40;                       // clamp case (R6)
    cnt_mem[12] = 8'd3;
    nbr_mem[12*MD + 0] = 6'd12;                // self loop (R4)
    nbr_mem[20*MD + 1] = nbr_mem[20*MD + 0];   // repeated neighbour (R4)

    rst_n = 1'b0;
    tgt_load = 1'b0; tgt_id = '0; tgt_ts = '0; go = 1'b0; s_ready = 1'b0;
    cnt_rd_data = '0; tri_rd_nbr = '0; tri_rd_ts = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(!s_valid && !done && !cnt_rd_en && !tri_rd_en, "R3 reset state",
        {s_valid, done, cnt_rd_en, tri_rd_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table, one batch per group, ready pattern by batch (R1, R2, R5)
    for (int b = 0; b < 3; b++) begin
      nk = 0;
      for (int v = 0; v < NVEC; v++) begin
        if (int'(VEC[v][25:22]) == b) load_tgt(int'(VEC[v][21:16]), int'(VEC[v][15:0]));
      end
      build_expected();
      run_batch(b, 1'b0);
      compare_edges(b);
    end

    // directed: list emptied after a batch (R9)
    empty_batch("after batches");

    // directed: go and load during a walk are ignored (R10)
    nk = 0;
    for (int v = 0; v < 4; v++) load_tgt(int'(VEC[v][21:16]), int'(VEC[v][15:0]));
    build_expected();
    run_batch(1, 1'b1);
    compare_edges(3);
    begin
      bit extra = 1'b0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        #2;
        if (done || s_valid) extra = 1'b1;
      end
      chk(!extra, "R10 no second batch from busy go", extra, 0);
    end
    empty_batch("R10 busy load dropped");

    // directed: all-duplicate timestamps keep lower id first (R2)
    nk = 0;
    load_tgt(44, 5);
    load_tgt(2, 5);
    load_tgt(23, 5);
    build_expected();
    run_batch(2, 1'b0);
    compare_edges(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule